// File: doc/BRIEF.md
# Auto-Reload Decrementer With Interrupt Latch

This block is a down-counter that steps once on every clock cycle where the time-base tick enable is high. When a tick takes the count from one to zero, the block records the event in a sticky status flag. The interrupt output is that flag gated by an interrupt-enable control bit. Software clears the flag by writing a one to it.

With auto-reload enabled, the zero event loads the counter from a separate reload register instead of leaving it at zero. The block skips the reload when the reload register holds zero. This keeps a zero reload value from causing an endless train of events.

Software reaches the counter, the reload register, the control bits and the status flag through a single-cycle write port and a combinational read port. Each register has a 2-bit address: counter 0, reload 1, control 2, status 3.

Top module: `dec_timer`

## Requirements
- R1: After reset, the counter, the reload register, control and status all read 0, and `irq` is 0.
- R2: On a cycle with `tick_en` high and no counter write, a nonzero counter decreases by exactly 1. With `tick_en` low, the counter holds its value.
- R3: A tick that moves the counter from 1 to 0 sets the status flag (status bit 0) at the same clock edge.
- R4: `irq` equals the status flag AND control bit 0 (interrupt enable), combinationally.
- R5: Under certain conditions, a zero event loads the counter with the reload register value instead of 0. The conditions are: control bit 1 (auto-reload) is set, and the reload register is nonzero.
- R6: If auto-reload is set but the reload register is 0, the counter stays at 0 after the event. Further ticks set the flag again only after software writes a new count.
- R7: With auto-reload clear, the counter stays at 0 after the event, and further ticks do not set the flag again.
- R8: A status write with data bit 0 set clears the flag. A status write with data bit 0 clear leaves the flag unchanged.
- R9: A counter write in the same cycle as a tick wins over the decrement and the reload. The counter takes the written value, and no zero event occurs in that cycle.
- R10: If a zero event and a status clear write fall in the same cycle, the flag ends set.
- R11: The reload register reads back its written value. Control reads back bits 1:0 as written, with all upper bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Time-base tick; counter steps when high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 count, 1 reload, 2 control, 3 status) |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 2 | Read address, same map |
| rd_data | output | CNT_W | Combinational read data |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situations to reach need a tick to land exactly when the counter holds 1, combined with another event in the same cycle. That other event may be a status clear, a counter write, or a zero reload value. Random stimulus rarely builds a 32-bit count down to 1 on its own. The bench therefore writes counts from a small range (0 to 5) and ticks on most cycles, so zero events occur often. Directed sequences then place the clear, the counter write and the zero reload precisely on the event cycle.

// File: rtl/dec_pkg.sv
package dec_pkg;
   typedef enum logic [1:0] {
      DR_COUNT  = 2'd0,
      DR_RELOAD = 2'd1,
      DR_CTRL   = 2'd2,
      DR_STATUS = 2'd3
   } dec_reg_e;

   localparam int CTL_W  = 2;
   localparam int CTL_IE = 0;   // interrupt enable
   localparam int CTL_AR = 1;   // auto-reload enable
endpackage

// File: rtl/dec_count.sv
module dec_count #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             load_en,
   input  logic [CNT_W-1:0] load_val,
   input  logic             auto_rel,
   input  logic [CNT_W-1:0] rel_val,
   output logic [CNT_W-1:0] cnt_q,
   output logic             zero_evt
);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] ZERO = '0;

   logic [CNT_W-1:0] cnt_d;
   logic             rel_ok;

   assign zero_evt = tick_en && !load_en && (cnt_q == ONE);
   assign rel_ok   = auto_rel && (rel_val != ZERO);

   always_comb begin
      cnt_d = cnt_q;
      if (load_en)
         cnt_d = load_val;
      else if (zero_evt)
         cnt_d = rel_ok ? rel_val : ZERO;
      else if (tick_en && cnt_q != ZERO)
         cnt_d = cnt_q - ONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end
endmodule

// File: rtl/dec_regs.sv
module dec_regs
   import dec_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  dec_reg_e         wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             zero_evt,
   output logic [CNT_W-1:0] rel_q,
   output logic [CTL_W-1:0] ctl_q,
   output logic             flag_q
);
   logic clr_req;
   assign clr_req = wr_en && (wr_sel == DR_STATUS) && wr_data[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rel_q  <= '0;
         ctl_q  <= '0;
         flag_q <= 1'b0;
      end else begin
         if (wr_en && wr_sel == DR_RELOAD) rel_q <= wr_data;
         if (wr_en && wr_sel == DR_CTRL)   ctl_q <= wr_data[CTL_W-1:0];
         if (zero_evt)      flag_q <= 1'b1;
         else if (clr_req)  flag_q <= 1'b0;
      end
   end
endmodule

// File: rtl/dec_irq.sv
module dec_irq #(
   parameter bit IRQ_REGISTERED = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic flag,
   input  logic enable,
   output logic irq
);
   generate
      if (IRQ_REGISTERED) begin : g_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq <= 1'b0;
            else        irq <= flag & enable;
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign irq = flag & enable;
      end
   endgenerate
endmodule

// File: rtl/dec_timer.sv
module dec_timer
   import dec_pkg::*;
#(
   parameter int CNT_W          = 32,
   parameter bit IRQ_REGISTERED = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic [1:0]       rd_addr,
   output logic [CNT_W-1:0] rd_data,
   output logic             irq
);
   generate
      if (CNT_W < 2 || CNT_W > 64) begin : g_bad_width
         $error("dec_timer: CNT_W must be in 2..64");
      end
   endgenerate

   dec_reg_e         wr_sel;
   logic [CNT_W-1:0] cnt_q, rel_q;
   logic [CTL_W-1:0] ctl_q;
   logic             flag_q, zero_evt, cnt_wr;

   assign wr_sel = dec_reg_e'(wr_addr);
   assign cnt_wr = wr_en && (wr_sel == DR_COUNT);

   dec_count #(.CNT_W(CNT_W)) u_count (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .load_en(cnt_wr), .load_val(wr_data),
      .auto_rel(ctl_q[CTL_AR]), .rel_val(rel_q),
      .cnt_q(cnt_q), .zero_evt(zero_evt)
   );

   dec_regs #(.CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .zero_evt(zero_evt),
      .rel_q(rel_q), .ctl_q(ctl_q), .flag_q(flag_q)
   );

   dec_irq #(.IRQ_REGISTERED(IRQ_REGISTERED)) u_irq (
      .clk(clk), .rst_n(rst_n), .flag(flag_q),
      .enable(ctl_q[CTL_IE]), .irq(irq)
   );

   always_comb begin
      rd_data = '0;
      case (dec_reg_e'(rd_addr))
         DR_COUNT:  rd_data = cnt_q;
         DR_RELOAD: rd_data = rel_q;
         DR_CTRL:   rd_data[CTL_W-1:0] = ctl_q;
         DR_STATUS: rd_data[0] = flag_q;
         default:   rd_data = '0;
      endcase
   end
endmodule

// File: rtl/dec_timer_chk.sv
module dec_timer_chk #(
   parameter int CNT_W          = 32,
   parameter bit IRQ_REGISTERED = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_en,
   input logic             wr_en,
   input logic [1:0]       wr_addr,
   input logic [CNT_W-1:0] wr_data,
   input logic [CNT_W-1:0] cnt_q,
   input logic             flag_q,
   input logic [1:0]       ctl_q,
   input logic             irq
);
   logic cnt_wr, st_clr, hit;
   assign cnt_wr = wr_en && wr_addr == 2'd0;
   assign st_clr = wr_en && wr_addr == 2'd3 && wr_data[0];
   assign hit    = tick_en && !cnt_wr && cnt_q == CNT_W'(1);

   // R2
   decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && !cnt_wr && cnt_q > CNT_W'(1)) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

   // R3
   event_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> flag_q);

   // R6
   zero_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0 && !cnt_wr) |=> cnt_q == '0);

   // R8
   clear_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_clr && !hit) |=> !flag_q);

   // R9
   write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> cnt_q == $past(wr_data));

   generate
      if (!IRQ_REGISTERED) begin : g_irq_chk
         // R4
         irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq == (flag_q && ctl_q[0]));
      end
   endgenerate
endmodule

bind dec_timer dec_timer_chk #(.CNT_W(CNT_W), .IRQ_REGISTERED(IRQ_REGISTERED)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
   .wr_addr(wr_addr), .wr_data(wr_data), .cnt_q(cnt_q),
   .flag_q(flag_q), .ctl_q(ctl_q), .irq(irq)
);

// File: tb/dec_timer_tb.sv
module dec_timer_tb;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tick_en = 1'b0, wr_en = 1'b0;
   logic [1:0]   wr_addr = '0, rd_addr = '0;
   logic [W-1:0] wr_data = '0;
   logic [W-1:0] rd_data;
   logic         irq;

   int total = 0, bad = 0;
   bit done = 1'b0;

   // bench model
   logic [W-1:0] m_cnt = '0, m_rel = '0;
   logic [1:0]   m_ctl = '0;
   logic         m_flag = 1'b0;

   always #10 clk = ~clk;

   dec_timer #(.CNT_W(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .irq(irq)
   );

   task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got=%0h exp=%0h at %0t", req, got, exp, $time);
      end
   endtask

   function automatic logic [W-1:0] exp_read(input logic [1:0] a);
      case (a)
         2'd0: return m_cnt;
         2'd1: return m_rel;
         2'd2: return {{(W-2){1'b0}}, m_ctl};
         default: return {{(W-1){1'b0}}, m_flag};
      endcase
   endfunction

   function automatic string tag_of(input logic [1:0] a);
      case (a)
         2'd0: return "R2 count";
         2'd1: return "R11 reload";
         2'd2: return "R11 ctrl";
         default: return "R3 status";
      endcase
   endfunction

   // one clock: drive at negedge, advance the model, compare after the edge
   task automatic step(input logic t, input logic we, input logic [1:0] wa,
                       input logic [W-1:0] wd, input logic [1:0] ra);
      logic evt;
      logic cw;
      @(negedge clk);
      tick_en = t; wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
      cw  = we && wa == 2'd0;
      evt = t && !cw && m_cnt == W'(1);
      @(posedge clk);
      if (cw)                     m_cnt = wd;
      else if (evt)               m_cnt = (m_ctl[1] && m_rel != '0) ? m_rel : '0;
      else if (t && m_cnt != '0)  m_cnt = m_cnt - W'(1);
      if (we && wa == 2'd1) m_rel = wd;
      if (we && wa == 2'd2) m_ctl = wd[1:0];
      if (evt)                          m_flag = 1'b1;
      else if (we && wa == 2'd3 && wd[0]) m_flag = 1'b0;
      #2;
      chk(tag_of(ra), rd_data, exp_read(ra));
      chk("R4 irq", {{(W-1){1'b0}}, irq}, {{(W-1){1'b0}}, m_flag & m_ctl[0]});
   endtask

   task automatic rd(input logic [1:0] a);
      step(1'b0, 1'b0, 2'd0, '0, a);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: got=hung exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state while reset held
      chk("R1 irq", {{(W-1){1'b0}}, irq}, '0);
      chk("R1 count", rd_data, '0);
      @(negedge clk); rst_n = 1'b1;
      for (int a = 0; a < 4; a++) begin
         rd(2'(a));
         chk("R1 reg", rd_data, '0);
      end

      // R3 / R6: auto-reload on, reload value zero
      step(1'b0, 1'b1, 2'd2, 32'h3, 2'd2);       // IE + AR
      chk("R11 ctrl", rd_data, 32'h3);
      step(1'b0, 1'b1, 2'd0, 32'd2, 2'd0);
      step(1'b1, 1'b0, 2'd0, '0, 2'd0);
      chk("R2 dec", rd_data, 32'd1);
      step(1'b1, 1'b0, 2'd0, '0, 2'd3);
      chk("R3 flag", rd_data, 32'd1);
      chk("R4 irq on", {{(W-1){1'b0}}, irq}, 32'd1);
      step(1'b0, 1'b1, 2'd3, 32'd1, 2'd3);
      chk("R8 clear", rd_data, 32'd0);
      step(1'b1, 1'b0, 2'd0, '0, 2'd0);
      step(1'b1, 1'b0, 2'd0, '0, 2'd0);
      chk("R6 stays zero", rd_data, 32'd0);
      rd(2'd3);
      chk("R6 no refire", rd_data, 32'd0);

      // R5: nonzero reload
      step(1'b0, 1'b1, 2'd1, 32'd5, 2'd1);
      chk("R11 reload", rd_data, 32'd5);
      step(1'b0, 1'b1, 2'd0, 32'd1, 2'd0);
      step(1'b1, 1'b0, 2'd0, '0, 2'd0);
      chk("R5 reload", rd_data, 32'd5);
      // R8 write 0 leaves flag
      step(1'b0, 1'b1, 2'd3, 32'hFFFF_FFFE, 2'd3);
      chk("R8 keep", rd_data, 32'd1);
      // R10: event and clear in same cycle
      step(1'b0, 1'b1, 2'd3, 32'd1, 2'd3);
      step(1'b0, 1'b1, 2'd0, 32'd1, 2'd0);
      step(1'b1, 1'b1, 2'd3, 32'd1, 2'd3);
      chk("R10 flag wins", rd_data, 32'd1);

      // R7: no auto-reload, IE off
      step(1'b0, 1'b1, 2'd2, 32'h0, 2'd3);
      chk("R4 irq gated", {{(W-1){1'b0}}, irq}, 32'd0);
      step(1'b0, 1'b1, 2'd3, 32'd1, 2'd3);
      step(1'b0, 1'b1, 2'd0, 32'd1, 2'd0);
      step(1'b1, 1'b0, 2'd0, '0, 2'd3);
      chk("R7 flag", rd_data, 32'd1);
      step(1'b0, 1'b1, 2'd3, 32'd1, 2'd3);
      step(1'b1, 1'b0, 2'd0, '0, 2'd0);
      chk("R7 stays zero", rd_data, 32'd0);
      rd(2'd3);
      chk("R7 no refire", rd_data, 32'd0);

      // R9: counter write beats tick at 1
      step(1'b0, 1'b1, 2'd0, 32'd1, 2'd0);
      step(1'b1, 1'b1, 2'd0, 32'd7, 2'd0);
      chk("R9 write wins", rd_data, 32'd7);
      rd(2'd3);
      chk("R9 no event", rd_data, 32'd0);
      step(1'b0, 1'b0, 2'd0, '0, 2'd0);
      chk("R2 hold", rd_data, 32'd7);

      // constrained random
      for (int i = 0; i < 4000; i++) begin
         logic t, we;
         logic [1:0] wa, ra;
         logic [W-1:0] wd;
         t  = ($urandom_range(9) < 7);
         we = ($urandom_range(9) < 2);
         wa = 2'($urandom_range(3));
         ra = 2'($urandom_range(3));
         wd = ($urandom_range(7) == 0) ? W'($urandom) : W'($urandom_range(5));
         step(t, we, wa, wd, ra);
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule